// File: doc/BRIEF.md
# Floating-Point Constant Push Unit

This block sits in the load path of a stack-based floating-point unit. It decodes the second byte of the constant-load instructions and picks one of seven built-in constants: +1.0, +0.0, log2(10), log2(e), pi, log10(2) and ln(2). Each constant is stored with a 64-bit significand and two extra low bits. On every load the block rounds the constant to the 80-bit extended format, using the 2-bit rounding-control input. It then pushes the result onto an eight-entry register stack.

The unit owns the stack pointer, the per-entry tags and the eight 80-bit registers. A push first moves the pointer down by one, modulo 8. It then writes the new top entry. When that entry is already occupied, the push is an overflow. The block then writes the indefinite quiet NaN in place of the constant, sets the condition flag and pulses a stack-fault output for one cycle. Rounding a constant never raises an inexact indication and never touches the condition flag.

Top module: `fpu_ldconst`

## Requirements
- R1: A push happens only when `valid_i` is 1 and `op_i` is in 0xE8..0xEE. The low three bits of `op_i` select the constant: 0 = +1.0, 1 = log2(10), 2 = log2(e), 3 = pi, 4 = log10(2), 5 = ln(2), 6 = +0.0. Any other byte, or `valid_i` low, leaves the pointer, the tags, the registers, C1 and the fault output unchanged.
- R2: With `rc_i` = 00 (nearest), the pushed 80-bit patterns (sign/exponent, significand) are as follows. +1.0: 3FFF 8000000000000000. log2(10): 4000 D49A784BCD1B8AFE. log2(e): 3FFF B8AA3B295C17F0BC. pi: 4000 C90FDAA22168C235. log10(2): 3FFD 9A209A84FBCFF799. ln(2): 3FFE B17217F7D1CF79AC. +0.0: all zero.
- R3: With `rc_i` = 01 (toward minus infinity) or 11 (toward zero), each irrational constant is truncated. This gives the R2 significands of log2(e), pi, log10(2) and ln(2) minus one, and log2(10) unchanged. With `rc_i` = 10 (toward plus infinity), each irrational constant is one above its truncated significand. +1.0 and +0.0 are identical in every mode.
- R4: A push that does not overflow leaves C1 at 0 and the fault output at 0 in every rounding mode, including when the rounding went up.
- R5: A push moves `top_o` to `top_o - 1` modulo 8 and writes physical register `top_o - 1`. Bits [80i+79 : 80i] of `st_o` hold register i, with the sign at bit 79, the exponent at bits 78..64 and the significand at bits 63..0.
- R6: Tag i sits at `tag_o[2i+1:2i]`, coded 00 valid, 01 zero, 10 special, 11 empty. Reset empties all eight tags, sets `top_o` to 0 and clears C1 and the fault output. A pushed +0.0 is tagged 01 and any other pushed constant is tagged 00.
- R7: A push whose target register is not empty overflows. It still moves the pointer, writes FFFF C000000000000000 tagged 10, sets C1 to 1 and raises `fault_o` for exactly the cycle after the push.
- R8: C1 keeps its value until the next push, and `fault_o` is 0 in any cycle that does not follow an overflowing push.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Opcode strobe |
| op_i | input | 8 | Second opcode byte |
| rc_i | input | 2 | Rounding control |
| st_o | output | 640 | Eight 80-bit stack registers, register i at bits 80i+79..80i |
| tag_o | output | 16 | Eight 2-bit tags |
| top_o | output | 3 | Stack pointer |
| c1_o | output | 1 | Condition flag C1 |
| fault_o | output | 1 | Stack-fault pulse |

## Verification
Overflow detection and constant rounding are evaluated in the same cycle. The tag lookup at the decremented pointer decides whether the rounded constant or the NaN reaches the register file. The bench provokes this by filling all eight registers and then issuing a ninth push under each rounding mode. It checks that the NaN, tag 10, C1 = 1 and a single-cycle fault pulse appear, with no trace of the rounded value. Random runs then wrap the pointer many times across mixed legal and illegal bytes, and compare every register and tag against a bench model.

// File: rtl/fpu_ldconst_pkg.sv
package fpu_ldconst_pkg;
  localparam int SIG_W  = 64;
  localparam int EXT_W  = 2;
  localparam int EXP_W  = 15;
  localparam int REG_W  = 1 + EXP_W + SIG_W;
  localparam int DEPTH  = 8;
  localparam int PTR_W  = $clog2(DEPTH);
  localparam int RAW_W  = SIG_W + EXT_W;

  typedef enum logic [1:0] {
    RC_NEAR = 2'b00,
    RC_DOWN = 2'b01,
    RC_UP   = 2'b10,
    RC_ZERO = 2'b11
  } rc_e;

  typedef enum logic [1:0] {
    TAG_VALID   = 2'b00,
    TAG_ZERO    = 2'b01,
    TAG_SPECIAL = 2'b10,
    TAG_EMPTY   = 2'b11
  } tag_e;

  typedef struct packed {
    logic             sign;
    logic [EXP_W-1:0] exp;
    logic [RAW_W-1:0] sig;
    tag_e             tag;
  } raw_const_t;

  typedef struct packed {
    logic             sign;
    logic [EXP_W-1:0] exp;
    logic [SIG_W-1:0] sig;
  } ext_t;

  localparam ext_t QNAN_IND = '{sign: 1'b1, exp: {EXP_W{1'b1}},
                                sig: {2'b11, {(SIG_W-2){1'b0}}}};
endpackage

// File: rtl/fpu_const_rom.sv
module fpu_const_rom
  import fpu_ldconst_pkg::*;
(
  input  logic [2:0] sel_i,
  output raw_const_t c_o
);
  // significand followed by two bits below the target precision
  always_comb begin
    c_o = '{sign: 1'b0, exp: '0, sig: '0, tag: TAG_ZERO};
    unique case (sel_i)
      3'd0: c_o = '{1'b0, 15'h3fff, {64'h8000_0000_0000_0000, 2'b00}, TAG_VALID};
      3'd1: c_o = '{1'b0, 15'h4000, {64'hd49a_784b_cd1b_8afe, 2'b01}, TAG_VALID};
      3'd2: c_o = '{1'b0, 15'h3fff, {64'hb8aa_3b29_5c17_f0bb, 2'b10}, TAG_VALID};
      3'd3: c_o = '{1'b0, 15'h4000, {64'hc90f_daa2_2168_c234, 2'b11}, TAG_VALID};
      3'd4: c_o = '{1'b0, 15'h3ffd, {64'h9a20_9a84_fbcf_f798, 2'b10}, TAG_VALID};
      3'd5: c_o = '{1'b0, 15'h3ffe, {64'hb172_17f7_d1cf_79ab, 2'b11}, TAG_VALID};
      default: c_o = '{1'b0, 15'h0000, {RAW_W{1'b0}}, TAG_ZERO};
    endcase
  end
endmodule

// File: rtl/fpu_const_round.sv
module fpu_const_round
  import fpu_ldconst_pkg::*;
(
  input  raw_const_t c_i,
  input  logic [1:0] rc_i,
  output ext_t       val_o,
  output tag_e       tag_o
);
  logic            guard_b, low_b, inc;
  logic [SIG_W:0]  sum;

  assign guard_b = c_i.sig[EXT_W-1];
  assign low_b   = |c_i.sig[EXT_W-2:0];

  // stored constants are irrational or exact: guard set means above half
  always_comb begin
    unique case (rc_e'(rc_i))
      RC_NEAR: inc = guard_b;
      RC_UP:   inc = guard_b | low_b;
      default: inc = 1'b0;
    endcase
  end

  assign sum = {1'b0, c_i.sig[RAW_W-1:EXT_W]} + {{SIG_W{1'b0}}, inc};

  always_comb begin
    val_o.sign = c_i.sign;
    if (sum[SIG_W]) begin
      val_o.exp = c_i.exp + 1'b1;
      val_o.sig = {1'b1, {(SIG_W-1){1'b0}}};
    end else begin
      val_o.exp = c_i.exp;
      val_o.sig = sum[SIG_W-1:0];
    end
  end

  assign tag_o = c_i.tag;
endmodule

// File: rtl/fpu_reg_stack.sv
module fpu_reg_stack
  import fpu_ldconst_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   push_i,
  input  ext_t                   wr_val_i,
  input  tag_e                   wr_tag_i,
  output logic                   full_hit_o,
  output logic [DEPTH*REG_W-1:0] st_o,
  output logic [2*DEPTH-1:0]     tag_o,
  output logic [PTR_W-1:0]       top_o
);
  logic [PTR_W-1:0] top_q, top_nxt;
  logic [1:0]       tag_q [DEPTH];

  assign top_nxt    = top_q - 1'b1;
  assign full_hit_o = tag_q[top_nxt] != TAG_EMPTY;
  assign top_o      = top_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     top_q <= '0;
    else if (push_i) top_q <= top_nxt;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic [REG_W-1:0] val_q;
    logic             sel;
    assign sel = push_i && (top_nxt == PTR_W'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        val_q    <= '0;
        tag_q[i] <= TAG_EMPTY;
      end else if (sel) begin
        val_q    <= wr_val_i;
        tag_q[i] <= wr_tag_i;
      end
    end

    assign st_o[i*REG_W +: REG_W] = val_q;
    assign tag_o[2*i +: 2]        = tag_q[i];
  end
endmodule

// File: rtl/fpu_ldconst.sv
module fpu_ldconst
  import fpu_ldconst_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   valid_i,
  input  logic [7:0]             op_i,
  input  logic [1:0]             rc_i,
  output logic [DEPTH*REG_W-1:0] st_o,
  output logic [2*DEPTH-1:0]     tag_o,
  output logic [PTR_W-1:0]       top_o,
  output logic                   c1_o,
  output logic                   fault_o
);
  localparam logic [4:0] OP_HI = 5'b11101;

  logic       push, full_hit;
  raw_const_t raw;
  ext_t       rounded, wr_val;
  tag_e       rnd_tag, wr_tag;

  assign push = valid_i && (op_i[7:3] == OP_HI) && (op_i[2:0] != 3'b111);

  fpu_const_rom u_rom (
    .sel_i (op_i[2:0]),
    .c_o   (raw)
  );

  fpu_const_round u_round (
    .c_i   (raw),
    .rc_i  (rc_i),
    .val_o (rounded),
    .tag_o (rnd_tag)
  );

  assign wr_val = full_hit ? QNAN_IND : rounded;
  assign wr_tag = full_hit ? TAG_SPECIAL : rnd_tag;

  fpu_reg_stack u_stack (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (push),
    .wr_val_i   (wr_val),
    .wr_tag_i   (wr_tag),
    .full_hit_o (full_hit),
    .st_o       (st_o),
    .tag_o      (tag_o),
    .top_o      (top_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      c1_o    <= 1'b0;
      fault_o <= 1'b0;
    end else begin
      if (push) c1_o <= full_hit;
      fault_o <= push && full_hit;
    end
  end
endmodule

// File: rtl/fpu_ldconst_chk.sv
module fpu_ldconst_chk
  import fpu_ldconst_pkg::*;
(
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   valid_i,
  input logic [7:0]             op_i,
  input logic [1:0]             rc_i,
  input logic [DEPTH*REG_W-1:0] st_o,
  input logic [2*DEPTH-1:0]     tag_o,
  input logic [PTR_W-1:0]       top_o,
  input logic                   c1_o,
  input logic                   fault_o
);
  logic             legal;
  logic [PTR_W-1:0] below;
  logic [1:0]       tag_top, tag_below;
  logic [REG_W-1:0] st0;

  assign legal     = valid_i && (op_i[7:3] == 5'b11101) && (op_i[2:0] != 3'b111);
  assign below     = top_o - 1'b1;
  assign tag_top   = tag_o[2*int'(top_o) +: 2];
  assign tag_below = tag_o[2*int'(below) +: 2];
  assign st0       = st_o[REG_W*int'(top_o) +: REG_W];

  // R5
  top_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    legal |=> top_o == $past(top_o) - 1'b1);

  // R1
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !legal |=> $stable(top_o) && $stable(tag_o) && $stable(st_o));

  // R7
  fault_c1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> c1_o && st0 == QNAN_IND && tag_top == TAG_SPECIAL);

  // R4
  clean_push_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    legal && tag_below == TAG_EMPTY |=> !c1_o && !fault_o);

  // R8
  c1_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !legal |=> $stable(c1_o) && !fault_o);

  // R6
  filled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    legal |=> tag_top != TAG_EMPTY);
endmodule

bind fpu_ldconst fpu_ldconst_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .op_i    (op_i),
  .rc_i    (rc_i),
  .st_o    (st_o),
  .tag_o   (tag_o),
  .top_o   (top_o),
  .c1_o    (c1_o),
  .fault_o (fault_o)
);

// File: tb/fpu_ldconst_test.sv
module fpu_ldconst_test;
  localparam int CLK_PERIOD = 10;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic [7:0]   op_i = 8'h00;
  logic [1:0]   rc_i = 2'b00;
  logic [639:0] st_o;
  logic [15:0]  tag_o;
  logic [2:0]   top_o;
  logic         c1_o, fault_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [79:0] m_reg [8];
  logic [1:0]  m_tag [8];
  logic [2:0]  m_top;
  logic        m_c1, m_fault;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  fpu_ldconst uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i), .rc_i(rc_i),
    .st_o(st_o), .tag_o(tag_o), .top_o(top_o), .c1_o(c1_o), .fault_o(fault_o)
  );

  function automatic logic [79:0] expect_val(input int idx, input logic [1:0] rc);
    logic [15:0] se;
    logic [63:0] tr;
    logic        near_up, up;
    near_up = 1'b1;
    case (idx)
      0: return {16'h3fff, 64'h8000_0000_0000_0000};
      1: begin se = 16'h4000; tr = 64'hd49a_784b_cd1b_8afe; near_up = 1'b0; end
      2: begin se = 16'h3fff; tr = 64'hb8aa_3b29_5c17_f0bb; end
      3: begin se = 16'h4000; tr = 64'hc90f_daa2_2168_c234; end
      4: begin se = 16'h3ffd; tr = 64'h9a20_9a84_fbcf_f798; end
      5: begin se = 16'h3ffe; tr = 64'hb172_17f7_d1cf_79ab; end
      default: return 80'h0;
    endcase
    up = (rc == 2'b00) ? near_up : (rc == 2'b10);
    return {se, tr + {63'h0, up}};
  endfunction

  task automatic chk(input string req, input logic [79:0] act, input logic [79:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, expv);
    end
  endtask

  task automatic compare_all(input string req);
    chk({req, " top R5"}, 80'(top_o), 80'(m_top));
    chk({req, " c1 R4"}, 80'(c1_o), 80'(m_c1));
    chk({req, " fault R7"}, 80'(fault_o), 80'(m_fault));
    for (int i = 0; i < 8; i++) begin
      chk({req, " tag R6"}, 80'(tag_o[2*i +: 2]), 80'(m_tag[i]));
      chk({req, " reg R2"}, st_o[80*i +: 80], m_reg[i]);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    valid_i = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    for (int i = 0; i < 8; i++) begin
      m_reg[i] = '0;
      m_tag[i] = 2'b11;
    end
    m_top = 3'd0;
    m_c1 = 1'b0;
    m_fault = 1'b0;
  endtask

  task automatic do_op(input logic v, input logic [7:0] op, input logic [1:0] rc,
                       input string req);
    logic [2:0] nt;
    @(negedge clk_i);
    valid_i = v;
    op_i = op;
    rc_i = rc;
    @(negedge clk_i);
    valid_i = 1'b0;
    if (v && op[7:3] == 5'b11101 && op[2:0] != 3'b111) begin
      nt = m_top - 3'd1;
      m_top = nt;
      if (m_tag[nt] != 2'b11) begin
        m_reg[nt] = {16'hffff, 64'hc000_0000_0000_0000};
        m_tag[nt] = 2'b10;
        m_c1 = 1'b1;
        m_fault = 1'b1;
      end else begin
        m_reg[nt] = expect_val(int'(op[2:0]), rc);
        m_tag[nt] = (op[2:0] == 3'd6) ? 2'b01 : 2'b00;
        m_c1 = 1'b0;
        m_fault = 1'b0;
      end
    end else begin
      m_fault = 1'b0;
    end
    compare_all(req);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    do_reset();
    // R6 reset state
    compare_all("R6 reset");

    // R2 R3 all constants in all modes, then overflow on a full stack
    for (int rc = 0; rc < 4; rc++) begin
      do_reset();
      for (int k = 0; k < 7; k++)
        do_op(1'b1, 8'he8 + 8'(k), 2'(rc), rc == 0 ? "R2 near" : "R3 directed");
      do_op(1'b1, 8'he8, 2'(rc), "R4 eighth push");
      do_op(1'b1, 8'heb, 2'(rc), "R7 overflow");
      do_op(1'b0, 8'he8, 2'(rc), "R8 idle after fault");
      do_op(1'b1, 8'hee, 2'(rc), "R7 overflow again");
    end

    // R1 ignored bytes
    do_reset();
    do_op(1'b1, 8'hef, 2'b00, "R1 byte EF");
    do_op(1'b1, 8'h12, 2'b10, "R1 foreign byte");
    do_op(1'b0, 8'he9, 2'b00, "R1 strobe low");
    do_op(1'b1, 8'hec, 2'b01, "R1 legal after");
    do_op(1'b1, 8'he7, 2'b10, "R1 byte E7");

    // random mix with periodic reset
    for (int n = 0; n < 400; n++) begin
      logic [7:0] op;
      if (n % 30 == 0) do_reset();
      op = ($urandom % 5 == 0) ? 8'($urandom) : 8'he8 + 8'($urandom % 7);
      do_op(($urandom % 8) != 0, op, 2'($urandom), "R5 random");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule